// File: doc/BRIEF.md
# Pipelined Multi-Page NAND Transfer Sequencer

This block schedules a multi-page NAND flash operation from a single start request. Software supplies an operation code, a page count, a bank number and a correction-strength setting, then pulses `startCmd`. The sequencer emits one-cycle start strobes with page indices to three external engines: the flash unit, the error corrector and the DMA mover. It collects their done pulses and steps forward in lock-step. It never implements the flash protocol, the BCH arithmetic or the DMA transfer itself.

Reads are overlapped. In step k the flash unit fetches page k, the corrector works on page k-1 and the DMA mover hands off page k-2. A read of N pages therefore takes N+2 steps, and the last two steps drain the pipeline. Programs and erases use the flash unit alone, one page per step, with no overlap. After each correction step the block writes a 16-bit status word for that page into its spare area. An error reported by the flash unit during a program or erase stops the sequence. Completion is signalled by a single-cycle interrupt pulse.

Top module: `nand_xfer_seq`

## Requirements
- R1: While `rstN` is low and after its release, `busy`, `irq`, `abortFlag`, `spareWrite` and all three start strobes are 0.
- R2: A start is taken only when the block is idle and `startCnt` is nonzero. A `startCmd` pulse with `startCnt`=0, or one arriving while `busy`=1, has no effect on the running or idle sequence.
- R3: For a read (`startOp`=0) of N pages, step k (k=0..N+1) asserts `fetchStart` with page k when k<N, `corrStart` with page k-1 when 1<=k<=N, and `dmaStart` with page k-2 when k>=2. All strobes of a step fall in the same cycle.
- R4: A step's strobes are issued only after every engine started in the previous step has returned its done pulse. A done pulse is counted only if it arrives at least one cycle after its strobe.
- R5: For a program (`startOp`=1) or erase (`startOp`=2), only `fetchStart` is used, once per page with pages 0..N-1 in order. The next page starts only after the previous page's `fetchDone`.
- R6: After each read step containing a correction, `spareWrite` pulses for one cycle with `spareIdx` equal to the corrected page. `spareWord` holds [15]=uncorrectable flag, [14:12]=strength code, [11:6]=check-byte count, [5:0]=error count, as reported with `corrDone`.
- R7: Strength codes 0..7 select 0, 4, 6, 8, 12, 16, 24 or 32 correctable bits, and the check-byte field reads 0, 8, 12, 15, 23, 30, 45 or 60 respectively.
- R8: A `fetchDone` together with `fetchErr` during a program or erase ends the sequence. No further strobes are issued, `irq` pulses and `abortFlag` is set. `abortFlag` clears when the next start is taken. `fetchErr` is ignored during reads.
- R9: When the last step completes, `irq` is high for exactly one cycle, and `busy` is already 0 in that cycle.
- R10: `bankOut` takes `startBank` when a start is taken and holds it for the whole sequence.
- R11: A read with `startCnt`=1 runs exactly three steps: a fetch, a correction and a DMA hand-off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startCmd | input | 1 | Start pulse |
| startOp | input | 2 | 0 read, 1 program, 2 erase |
| startCnt | input | CNT_W | Number of pages |
| startBank | input | BANK_W | Bank for the whole sequence |
| startEcc | input | 3 | Correction strength code |
| busy | output | 1 | Sequence in progress |
| irq | output | 1 | Completion pulse |
| abortFlag | output | 1 | Last sequence was stopped by a flash error |
| bankOut | output | BANK_W | Bank held for the sequence |
| fetchStart | output | 1 | Flash engine start strobe |
| fetchPage | output | CNT_W | Page for flash engine |
| fetchDone | input | 1 | Flash engine done |
| fetchErr | input | 1 | Flash engine error, valid with done |
| corrStart | output | 1 | Corrector start strobe |
| corrPage | output | CNT_W | Page for corrector |
| corrDone | input | 1 | Corrector done |
| corrErrCnt | input | ERR_W | Corrected bit count, valid with done |
| corrFail | input | 1 | Uncorrectable, valid with done |
| dmaStart | output | 1 | DMA start strobe |
| dmaPage | output | CNT_W | Page for DMA engine |
| dmaDone | input | 1 | DMA engine done |
| spareWrite | output | 1 | Status word write pulse |
| spareIdx | output | CNT_W | Page whose spare area receives the word |
| spareWord | output | 16 | Status word |

## Verification
Two events can fall in the same cycle here. The three engine strobes of one read step must coincide. The completion of one step, with its spare-area status write, must also line up with the late done pulse of a different engine, including the case where the correction done is the very last to arrive. The bench sweeps page counts and independent latencies for the flash, corrector and DMA responders so that each engine in turn is the last to finish a step. At every strobe it judges the full active set and page numbers against the step number it has counted. At each spare write it compares the word against one built from the strength table and the error counts the bench itself supplied.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
  localparam int ECC_W = 3;
  localparam int CB_W  = 6;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} seqStateT;

  typedef struct packed {
    logic loadCmd;   // latch a new command
    logic advance;   // current step finished, move on
  } seqCtlT;

  function automatic logic [CB_W-1:0] checkBytes(input logic [ECC_W-1:0] mode);
    case (mode)
      3'd0: checkBytes = 6'd0;
      3'd1: checkBytes = 6'd8;
      3'd2: checkBytes = 6'd12;
      3'd3: checkBytes = 6'd15;
      3'd4: checkBytes = 6'd23;
      3'd5: checkBytes = 6'd30;
      3'd6: checkBytes = 6'd45;
      default: checkBytes = 6'd60;
    endcase
  endfunction
endpackage

// File: rtl/nand_seq_ctrl.sv
module nand_seq_ctrl
  import nand_seq_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startCmd,
  input  logic [CNT_W-1:0] startCnt,
  input  logic             fetchDone,
  input  logic             fetchErr,
  input  logic             corrDone,
  input  logic             dmaDone,
  input  logic             isRead,
  input  logic             fetchAct,
  input  logic             corrAct,
  input  logic             dmaAct,
  input  logic             lastStep,
  output seqCtlT           ctl,
  output logic             fetchStart,
  output logic             corrStart,
  output logic             dmaStart,
  output logic             busy,
  output logic             irq,
  output logic             abortFlag
);
  seqStateT state;
  logic fSeen, cSeen, dSeen;
  logic allDone, wrFault;

  always_comb begin
    allDone = (!fetchAct || fSeen || fetchDone) &&
              (!corrAct  || cSeen || corrDone)  &&
              (!dmaAct   || dSeen || dmaDone);
    wrFault = (state == S_WAIT) && !isRead && fetchDone && fetchErr;
    ctl.loadCmd = (state == S_IDLE) && startCmd && (startCnt != '0);
    ctl.advance = (state == S_WAIT) && allDone && !wrFault;
  end

  assign fetchStart = (state == S_ISSUE) && fetchAct;
  assign corrStart  = (state == S_ISSUE) && corrAct;
  assign dmaStart   = (state == S_ISSUE) && dmaAct;
  assign busy       = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      fSeen     <= 1'b0;
      cSeen     <= 1'b0;
      dSeen     <= 1'b0;
      irq       <= 1'b0;
      abortFlag <= 1'b0;
    end else begin
      irq <= 1'b0;
      case (state)
        S_IDLE: if (ctl.loadCmd) begin
          state     <= S_ISSUE;
          abortFlag <= 1'b0;
        end
        S_ISSUE: begin
          fSeen <= 1'b0;
          cSeen <= 1'b0;
          dSeen <= 1'b0;
          state <= S_WAIT;
        end
        S_WAIT: begin
          fSeen <= fSeen | fetchDone;
          cSeen <= cSeen | corrDone;
          dSeen <= dSeen | dmaDone;
          if (wrFault) begin
            state     <= S_IDLE;
            irq       <= 1'b1;
            abortFlag <= 1'b1;
          end else if (ctl.advance) begin
            if (lastStep) begin
              state <= S_IDLE;
              irq   <= 1'b1;
            end else begin
              state <= S_ISSUE;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R9: completion pulse lasts one cycle
  p_irq_pulse_r9: assert property (@(posedge clk) disable iff (!rstN) irq |=> !irq);
  // R9: sequence already idle when completion is signalled
  p_irq_idle_r9: assert property (@(posedge clk) disable iff (!rstN) irq |-> !busy);
  // R5: flow-through operations never reach the corrector or DMA engine
  p_flow_only_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !isRead) |-> (!corrStart && !dmaStart));
  // R8: abort only comes from a program or erase
  p_abort_op_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(abortFlag) |-> !isRead);
  // R4: a step's strobes are single-cycle
  p_strobe_once_r4: assert property (@(posedge clk) disable iff (!rstN)
    fetchStart |=> !fetchStart);
endmodule

// File: rtl/nand_seq_dp.sv
module nand_seq_dp
  import nand_seq_pkg::*;
#(
  parameter int CNT_W  = 4,
  parameter int BANK_W = 2,
  parameter int ERR_W  = 6,
  localparam int SW     = CNT_W + 1,
  localparam int WORD_W = 1 + ECC_W + CB_W + ERR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtlT            ctl,
  input  logic [1:0]        startOp,
  input  logic [CNT_W-1:0]  startCnt,
  input  logic [BANK_W-1:0] startBank,
  input  logic [ECC_W-1:0]  startEcc,
  input  logic              corrDone,
  input  logic [ERR_W-1:0]  corrErrCnt,
  input  logic              corrFail,
  output logic              isRead,
  output logic              fetchAct,
  output logic              corrAct,
  output logic              dmaAct,
  output logic              lastStep,
  output logic [CNT_W-1:0]  fetchPage,
  output logic [CNT_W-1:0]  corrPage,
  output logic [CNT_W-1:0]  dmaPage,
  output logic [BANK_W-1:0] bankOut,
  output logic              spareWrite,
  output logic [CNT_W-1:0]  spareIdx,
  output logic [WORD_W-1:0] spareWord
);
  logic [CNT_W-1:0] pageCnt;
  logic [SW-1:0]    step, stepM1, stepM2, cntExt, totSteps;
  logic [ECC_W-1:0] eccMode;
  logic [ERR_W-1:0] errHold, errNow;
  logic             failHold, failNow;

  always_comb begin
    cntExt   = {1'b0, pageCnt};
    stepM1   = step - SW'(1);
    stepM2   = step - SW'(2);
    totSteps = isRead ? cntExt + SW'(2) : cntExt;
    lastStep = (step == totSteps - SW'(1));
    fetchAct = (step < cntExt);
    corrAct  = isRead && (step != '0) && (step <= cntExt);
    dmaAct   = isRead && (step >= SW'(2));
    fetchPage = step[CNT_W-1:0];
    corrPage  = stepM1[CNT_W-1:0];
    dmaPage   = stepM2[CNT_W-1:0];
    errNow  = corrDone ? corrErrCnt : errHold;
    failNow = corrDone ? corrFail : failHold;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      isRead     <= 1'b0;
      pageCnt    <= '0;
      step       <= '0;
      eccMode    <= '0;
      bankOut    <= '0;
      errHold    <= '0;
      failHold   <= 1'b0;
      spareWrite <= 1'b0;
      spareIdx   <= '0;
      spareWord  <= '0;
    end else begin
      spareWrite <= 1'b0;
      if (ctl.loadCmd) begin
        isRead  <= (startOp == 2'd0);
        pageCnt <= startCnt;
        eccMode <= startEcc;
        bankOut <= startBank;
        step    <= '0;
      end else if (ctl.advance) begin
        step <= step + SW'(1);
      end
      if (corrDone) begin
        errHold  <= corrErrCnt;
        failHold <= corrFail;
      end
      if (ctl.advance && corrAct) begin
        spareWrite <= 1'b1;
        spareIdx   <= corrPage;
        spareWord  <= {failNow, eccMode, checkBytes(eccMode), errNow};
      end
    end
  end

  // R6: status words only come from read sequences
  p_spare_read_r6: assert property (@(posedge clk) disable iff (!rstN) spareWrite |-> isRead);
  // R6: status write is a single-cycle pulse
  p_spare_pulse_r6: assert property (@(posedge clk) disable iff (!rstN) spareWrite |=> !spareWrite);
endmodule

// File: rtl/nand_xfer_seq.sv
module nand_xfer_seq
  import nand_seq_pkg::*;
#(
  parameter int CNT_W  = 4,
  parameter int BANK_W = 2,
  parameter int ERR_W  = 6,
  localparam int WORD_W = 1 + ECC_W + CB_W + ERR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startCmd,
  input  logic [1:0]        startOp,
  input  logic [CNT_W-1:0]  startCnt,
  input  logic [BANK_W-1:0] startBank,
  input  logic [ECC_W-1:0]  startEcc,
  output logic              busy,
  output logic              irq,
  output logic              abortFlag,
  output logic [BANK_W-1:0] bankOut,
  output logic              fetchStart,
  output logic [CNT_W-1:0]  fetchPage,
  input  logic              fetchDone,
  input  logic              fetchErr,
  output logic              corrStart,
  output logic [CNT_W-1:0]  corrPage,
  input  logic              corrDone,
  input  logic [ERR_W-1:0]  corrErrCnt,
  input  logic              corrFail,
  output logic              dmaStart,
  output logic [CNT_W-1:0]  dmaPage,
  input  logic              dmaDone,
  output logic              spareWrite,
  output logic [CNT_W-1:0]  spareIdx,
  output logic [WORD_W-1:0] spareWord
);
  seqCtlT ctl;
  logic isRead, fetchAct, corrAct, dmaAct, lastStep;

  nand_seq_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .startCmd(startCmd), .startCnt(startCnt),
    .fetchDone(fetchDone), .fetchErr(fetchErr), .corrDone(corrDone), .dmaDone(dmaDone),
    .isRead(isRead), .fetchAct(fetchAct), .corrAct(corrAct), .dmaAct(dmaAct),
    .lastStep(lastStep), .ctl(ctl), .fetchStart(fetchStart), .corrStart(corrStart),
    .dmaStart(dmaStart), .busy(busy), .irq(irq), .abortFlag(abortFlag)
  );

  nand_seq_dp #(.CNT_W(CNT_W), .BANK_W(BANK_W), .ERR_W(ERR_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .startOp(startOp), .startCnt(startCnt),
    .startBank(startBank), .startEcc(startEcc), .corrDone(corrDone),
    .corrErrCnt(corrErrCnt), .corrFail(corrFail), .isRead(isRead),
    .fetchAct(fetchAct), .corrAct(corrAct), .dmaAct(dmaAct), .lastStep(lastStep),
    .fetchPage(fetchPage), .corrPage(corrPage), .dmaPage(dmaPage), .bankOut(bankOut),
    .spareWrite(spareWrite), .spareIdx(spareIdx), .spareWord(spareWord)
  );

  // R10: bank is frozen for the whole sequence
  p_bank_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(bankOut));
endmodule

// File: tb/nand_xfer_seq_test.sv
module nand_xfer_seq_test;
  localparam int CNT_W = 4, BANK_W = 2, ERR_W = 6;

  logic clk = 1'b0, rstN = 1'b0;
  logic startCmd = 1'b0;
  logic [1:0] startOp = '0;
  logic [CNT_W-1:0] startCnt = '0;
  logic [BANK_W-1:0] startBank = '0;
  logic [2:0] startEcc = '0;
  logic busy, irq, abortFlag;
  logic [BANK_W-1:0] bankOut;
  logic fetchStart, corrStart, dmaStart;
  logic [CNT_W-1:0] fetchPage, corrPage, dmaPage, spareIdx;
  logic fetchDone = 1'b0, fetchErr = 1'b0, corrDone = 1'b0, corrFail = 1'b0, dmaDone = 1'b0;
  logic [ERR_W-1:0] corrErrCnt = '0;
  logic spareWrite;
  logic [15:0] spareWord;

  nand_xfer_seq #(.CNT_W(CNT_W), .BANK_W(BANK_W), .ERR_W(ERR_W)) uut (.*);

  always #2.5 clk = ~clk;

  int nChk = 0, nBad = 0, cycles = 0;
  int curN = 0, curEcc = 0, curBank = 0, errPg = -1;
  bit curRead = 0, failOn = 0;
  int dF = 1, dC = 1, dD = 1;
  int nF = 0, nC = 0, nD = 0, nS = 0, nSteps = 0, doneF = 0, doneC = 0, doneD = 0;
  int pgF = 0, pgC = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int cbOf(input int m);
    case (m)
      0: return 0; 1: return 8; 2: return 12; 3: return 15;
      4: return 23; 5: return 30; 6: return 45; default: return 60;
    endcase
  endfunction
  function automatic int errOf(input int p); return (p * 7 + 3) % 61; endfunction
  function automatic int expWord(input int p);
    return ((failOn && p == 2) ? 32768 : 0) + (curEcc << 12) + (cbOf(curEcc) << 6) + errOf(p);
  endfunction

  // flash engine responder
  initial forever begin
    @(negedge clk);
    fetchDone = 0; fetchErr = 0;
    if (fetchStart) begin
      pgF = int'(fetchPage);
      repeat (dF) @(negedge clk);
      fetchDone = 1; fetchErr = (pgF == errPg); doneF++;
    end
  end
  // corrector responder
  initial forever begin
    @(negedge clk);
    corrDone = 0; corrFail = 0; corrErrCnt = '0;
    if (corrStart) begin
      pgC = int'(corrPage);
      repeat (dC) @(negedge clk);
      corrDone = 1; corrFail = failOn && (pgC == 2); corrErrCnt = ERR_W'(errOf(pgC)); doneC++;
    end
  end
  // DMA responder
  initial forever begin
    @(negedge clk);
    dmaDone = 0;
    if (dmaStart) begin
      repeat (dD) @(negedge clk);
      dmaDone = 1; doneD++;
    end
  end

  // step and status monitor
  initial forever begin
    @(negedge clk);
    if (rstN && busy) chk(bankOut == BANK_W'(curBank), "R10 bank", int'(bankOut), curBank);
    if (rstN && (fetchStart || corrStart || dmaStart)) begin
      automatic int s = nSteps;
      automatic bit eF = s < curN;
      automatic bit eC = curRead && s >= 1 && s <= curN;
      automatic bit eD = curRead && s >= 2;
      chk({fetchStart, corrStart, dmaStart} == {eF, eC, eD}, curRead ? "R3 active set" : "R5 active set",
          int'({fetchStart, corrStart, dmaStart}), int'({eF, eC, eD}));
      chk(nF == doneF && nC == doneC && nD == doneD, "R4 previous step complete", nF + nC + nD, doneF + doneC + doneD);
      if (fetchStart) begin chk(int'(fetchPage) == s, "R3 fetch page", int'(fetchPage), s); nF++; end
      if (corrStart)  begin chk(int'(corrPage) == s - 1, "R3 corr page", int'(corrPage), s - 1); nC++; end
      if (dmaStart)   begin chk(int'(dmaPage) == s - 2, "R3 dma page", int'(dmaPage), s - 2); nD++; end
      nSteps++;
    end
    if (rstN && spareWrite) begin
      chk(int'(spareIdx) == nS, "R6 spare index", int'(spareIdx), nS);
      chk(int'(spareWord) == expWord(nS), "R6 R7 spare word", int'(spareWord), expWord(nS));
      nS++;
    end
  end

  task automatic runCmd(input int op, input int n, input int ecc, input int bank,
                        input int ePg, input bit fOn, input bit poke);
    automatic int t = 0;
    curN = n; curRead = (op == 0); curEcc = ecc; curBank = bank; errPg = ePg; failOn = fOn;
    nF = 0; nC = 0; nD = 0; nS = 0; nSteps = 0; doneF = 0; doneC = 0; doneD = 0;
    @(negedge clk);
    startOp = 2'(op); startCnt = CNT_W'(n); startEcc = 3'(ecc); startBank = BANK_W'(bank);
    startCmd = 1;
    @(negedge clk);
    startCmd = 0;
    if (poke) begin
      repeat (2) @(negedge clk);
      startOp = 2'd1; startCnt = 4'd9; startBank = BANK_W'(bank + 1); startCmd = 1;
      @(negedge clk);
      startCmd = 0;
    end
    while (!irq && t < 3000) begin @(negedge clk); t++; end
    chk(irq == 1'b1, "R9 irq raised", int'(irq), 1);
    chk(busy == 1'b0, "R9 idle with irq", int'(busy), 0);
    if (ePg >= 0 && op != 0) begin
      chk(abortFlag == 1'b1, "R8 abort flag", int'(abortFlag), 1);
      chk(nF == ePg + 1, "R8 no strobes after error", nF, ePg + 1);
    end else begin
      chk(abortFlag == 1'b0, "R8 no abort", int'(abortFlag), 0);
      chk(nF == n, curRead ? "R3 fetch count" : "R5 page count", nF, n);
      chk(nC == (curRead ? n : 0) && nD == (curRead ? n : 0), "R3 R5 corr/dma count", nC + nD, curRead ? 2 * n : 0);
      chk(nS == (curRead ? n : 0), "R6 spare count", nS, curRead ? n : 0);
      chk(nSteps == (curRead ? n + 2 : n), n == 1 && curRead ? "R11 single page steps" : "R3 step count",
          nSteps, curRead ? n + 2 : n);
    end
    @(negedge clk);
    chk(irq == 1'b0, "R9 irq one cycle", int'(irq), 0);
    repeat (3) @(negedge clk);
    chk(nF + nC + nD == doneF + doneC + doneD && !busy, "R2 no late start", int'(busy), 0);
  endtask

  initial begin
    int run = 0;
    repeat (3) @(negedge clk);
    chk(!busy && !irq && !abortFlag && !spareWrite && !fetchStart && !corrStart && !dmaStart,
        "R1 reset outputs", int'(busy), 0);
    rstN = 1;
    @(negedge clk);
    chk(!busy && !irq && !fetchStart && !spareWrite, "R1 after reset", int'(busy), 0);

    // R2: zero page count ignored
    startCnt = '0; startCmd = 1; @(negedge clk); startCmd = 0;
    repeat (3) @(negedge clk);
    chk(!busy && !fetchStart, "R2 zero count ignored", int'(busy), 0);

    // R3 R4 R6 R7 R11: read sweep across sizes and latencies
    for (int n = 1; n <= 5; n++)
      for (int a = 0; a < 2; a++)
        for (int b = 0; b < 3; b++)
          for (int c = 0; c < 2; c++) begin
            dF = a ? 3 : 1; dC = (b == 0) ? 1 : (b == 1 ? 2 : 4); dD = c ? 5 : 1;
            runCmd(0, n, run % 8, run % 4, -1, (run % 3) == 0, (run % 5) == 1);
            run++;
          end

    // R5: program and erase
    for (int n = 1; n <= 4; n++) begin
      dF = n; runCmd(1, n, 3, n % 4, -1, 0, n == 2);
    end
    dF = 2; runCmd(2, 3, 0, 1, -1, 0, 0);

    // R8: flash error aborts a program, then a read clears the flag
    dF = 1; runCmd(1, 4, 0, 2, 1, 0, 0);
    dF = 2; runCmd(2, 5, 0, 3, 0, 0, 0);
    dF = 1; dC = 1; dD = 1;
    runCmd(0, 3, 7, 0, 1, 0, 0);   // fetchErr ignored during a read (R8)

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    while (cycles < 150000) begin @(posedge clk); cycles++; end
    nChk++; nBad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule